// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is an SPI master that executes a list of up to sixteen transfers on its own once a host has prepared it. Through a simple write port the host loads a transmit word and a command entry for each slot, the first and last slot of the list, and a mode word that carries the clock divider, the clock polarity and phase, and a programmable transfer length. A one-cycle start pulse then makes the block walk the slots in order. For each slot it drives the chip-select pattern held in that slot's command, shifts the transmit word out most significant bit first, and captures the word returned on the input line.

Each received word is stored in a sixteen-entry receive memory at the index of the slot that produced it, and the host reads it back through a combinational read port. A busy output covers the whole run. A sticky done output marks that the last slot has finished and the chip selects have returned to their idle level.

Top module: `qspi_queue_master`

## Requirements
- R1: After reset `busy` and `done` are 0, `csel` is 4'hF, `sclk` is 0 and the divider is 0.
- R2: A start pulse while idle runs slots from the first pointer through the last pointer, advancing by one modulo 16 (last < first wraps through slot 15 to slot 0). Pointer write (`hw_sel`=2): `hw_data[3:0]` is the first slot, `hw_data[7:4]` the last.
- R3: During each slot's transfer `csel` equals bits [3:0] of that slot's command (`hw_sel`=1). When the block is not busy `csel` is 4'hF.
- R4: The transmit word (`hw_sel`=0) is right-justified and sent MSB first. Command bit 7 = 0 gives 8 bits. Bit 7 = 1 gives the length code in mode bits [13:10] when that code is 8..15, and 16 bits for any other code. Bits above the length are ignored.
- R5: The bits received in a slot are stored right-justified, with upper bits zero, at the same index in the receive memory. That memory is read through `rd_addr`/`rd_data`.
- R6: Mode bit 8 (CPOL) sets the idle level of `sclk`. With mode bit 9 (CPHA) = 0, `miso` is sampled on the first edge of each bit and `mosi` changes on the second. With CPHA = 1 this is reversed.
- R7: Mode bits [7:0] give the divider D. Each half period of `sclk` lasts D system clocks, with values 1 and 2 both giving 2.
- R8: While D = 0, `sclk` stops and the run stalls with `busy` held. Writing a nonzero D lets it resume.
- R9: `busy` rises on an accepted start and falls when the last slot completes. `done` is then set and stays set until the next accepted start clears it.
- R10: A start pulse while `busy` is ignored. The run in progress ends normally and does not restart.
- R11: Transmit words remain in place after a run and are sent again by later runs without being rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_en | input | 1 | Host write enable |
| hw_sel | input | 2 | Write target: 0 transmit, 1 command, 2 pointers, 3 mode |
| hw_addr | input | 4 | Slot index for transmit and command writes |
| hw_data | input | 16 | Host write data |
| start | input | 1 | One-cycle run request |
| rd_addr | input | 4 | Receive memory read index |
| rd_data | output | 16 | Receive memory read data |
| busy | output | 1 | Run in progress |
| done | output | 1 | Sticky run-complete flag |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csel | output | 4 | Chip-select levels, 4'hF when idle |

## Verification
The hardest case to reach from the ports is a run stalled part way through by a zero divider and then resumed. The stimulus starts a slot with D = 0 and holds the block there for a long time, confirming that no clock edge appears and that `busy` stays high. It then writes a nonzero divider through the host port while the run is still pending, and the scoreboard expects the full slot to complete with the resumed period. A second hard case is a list that wraps from slot 15 to slot 0 and reuses transmit words from an earlier run. The bench reaches it by setting the last pointer below the first and leaving those slots unwritten.

// File: rtl/qspi_pkg.sv
// Shared types for the queued SPI master.
// Assumes: nothing beyond IEEE 1800-2017.
package qspi_pkg;

    // Host write targets selected by hw_sel.
    typedef enum logic [1:0] {
        SEL_TX   = 2'd0,
        SEL_CMD  = 2'd1,
        SEL_PTR  = 2'd2,
        SEL_MODE = 2'd3
    } host_sel_e;

    // Sequencer states.
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_LOAD = 2'd1,
        SQ_RUN  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/qspi_baud_gen.sv
// Prescaler: emits one tick per sclk half period while run is high.
// Assumes: baud 0 stops ticking; baud 1 behaves as 2.
module qspi_baud_gen #(
    parameter int BAUD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [BAUD_W-1:0] baud,
    output logic              tick
);
    logic [BAUD_W-1:0] cnt;
    logic [BAUD_W-1:0] div;
    logic              off;

    // Effective divider with the lower clamp.
    always_comb begin
        off = (baud == '0);
        div = (baud < BAUD_W'(2)) ? BAUD_W'(2) : baud;
        tick = run && !off && (cnt == div - 1'b1);
    end

    // Half-period counter, cleared when not running.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (!run || off)  cnt <= '0;
        else if (tick)         cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/qspi_shift_engine.sv
// Serial engine: runs one transfer of len bits MSB first on go.
// Assumes: go only while inactive; tick spaced at least 2 clocks.
module qspi_shift_engine #(
    parameter int WORD_W = 16,
    parameter int LEN_W  = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              tick,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [LEN_W-1:0]  len,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              active,
    output logic              fin,
    output logic [WORD_W-1:0] rx_word
);
    localparam int EDGE_W = $clog2(2 * WORD_W);
    localparam int IDX_W  = $clog2(WORD_W);

    logic [EDGE_W-1:0] edge_cnt;
    logic [WORD_W-1:0] tx_sr;
    logic [WORD_W-1:0] rx_sr;
    logic              sclk_q;
    logic [LEN_W-1:0]  msb_idx;
    logic              sample_now;
    logic              shift_now;
    logic              last_edge;

    // Edge classification for the current tick.
    always_comb begin
        msb_idx    = len - 1'b1;
        sample_now = (edge_cnt[0] == cpha);
        shift_now  = (edge_cnt[0] != cpha) && !(cpha && edge_cnt == '0);
        last_edge  = (int'(edge_cnt) == 2 * int'(len) - 1);
    end

    // Shift registers, edge counter and serial clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            fin      <= 1'b0;
            edge_cnt <= '0;
            tx_sr    <= '0;
            rx_sr    <= '0;
            sclk_q   <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                active   <= 1'b1;
                edge_cnt <= '0;
                tx_sr    <= tx_word;
                rx_sr    <= '0;
                sclk_q   <= cpol;
            end else if (active && tick) begin
                sclk_q   <= ~sclk_q;
                edge_cnt <= edge_cnt + 1'b1;
                if (sample_now) rx_sr <= {rx_sr[WORD_W-2:0], miso};
                if (shift_now)  tx_sr <= tx_sr << 1;
                if (last_edge) begin
                    active <= 1'b0;
                    fin    <= 1'b1;
                end
            end
        end
    end

    assign sclk    = active ? sclk_q : cpol;
    assign mosi    = tx_sr[msb_idx[IDX_W-1:0]];
    assign rx_word = rx_sr;
endmodule

// File: rtl/qspi_sequencer.sv
// Queue walker: steps slot pointer from first to last, drives chip
// selects, launches transfers and requests receive writes.
// Assumes: fin is a one-cycle pulse after each launched transfer.
module qspi_sequencer
    import qspi_pkg::*;
#(
    parameter int PTR_W = 4,
    parameter int CS_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [PTR_W-1:0] first_ptr,
    input  logic [PTR_W-1:0] last_ptr,
    input  logic [CS_W-1:0]  cs_pat,
    input  logic             fin,
    output logic [PTR_W-1:0] ptr,
    output logic             busy,
    output logic             done,
    output logic [CS_W-1:0]  csel,
    output logic             go,
    output logic             rx_we
);
    seq_state_e state;

    // Receive write lands on the cycle the transfer reports completion.
    assign rx_we = (state == SQ_RUN) && fin;

    // Queue state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
            ptr   <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
            csel  <= '1;
            go    <= 1'b0;
        end else begin
            go <= 1'b0;
            case (state)
                SQ_IDLE: if (start) begin
                    ptr   <= first_ptr;
                    busy  <= 1'b1;
                    done  <= 1'b0;
                    state <= SQ_LOAD;
                end
                SQ_LOAD: begin
                    csel  <= cs_pat;
                    go    <= 1'b1;
                    state <= SQ_RUN;
                end
                SQ_RUN: if (fin) begin
                    if (ptr == last_ptr) begin
                        csel  <= '1;
                        busy  <= 1'b0;
                        done  <= 1'b1;
                        state <= SQ_IDLE;
                    end else begin
                        ptr   <= ptr + 1'b1;
                        state <= SQ_LOAD;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/qspi_queue_master.sv
// Top: host-loaded slot memories, mode register, receive memory, and
// the sequencer, prescaler and shift engine.
// Assumes: DEPTH is a power of two; WORD_W >= 14 so the mode word fits.
module qspi_queue_master
    import qspi_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 16,
    parameter int CS_W   = 4,
    parameter int BAUD_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hw_en,
    input  logic [1:0]               hw_sel,
    input  logic [$clog2(DEPTH)-1:0] hw_addr,
    input  logic [WORD_W-1:0]        hw_data,
    input  logic                     start,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [WORD_W-1:0]        rd_data,
    output logic                     busy,
    output logic                     done,
    output logic                     sclk,
    output logic                     mosi,
    input  logic                     miso,
    output logic [CS_W-1:0]          csel
);
    localparam int PTR_W    = $clog2(DEPTH);
    localparam int LEN_W    = $clog2(WORD_W + 1);
    localparam int CODE_W   = 4;
    localparam int LSEL_BIT = 7;
    localparam int CPOL_BIT = BAUD_W;
    localparam int CPHA_BIT = BAUD_W + 1;
    localparam int CODE_LO  = BAUD_W + 2;

    logic [WORD_W-1:0] tx_mem  [DEPTH];
    logic [CS_W-1:0]   cs_mem  [DEPTH];
    logic              lsel_mem[DEPTH];
    logic [WORD_W-1:0] rx_mem  [DEPTH];

    logic [PTR_W-1:0]  first_q, last_q;
    logic [BAUD_W-1:0] mode_baud;
    logic              mode_cpol, mode_cpha;
    logic [CODE_W-1:0] mode_code;

    logic [PTR_W-1:0]  ptr;
    logic              go, fin, rx_we, tick, active;
    logic [LEN_W-1:0]  xfer_len;
    logic [WORD_W-1:0] rx_word;

    // Host writes into slot memories and configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                tx_mem[i]   <= '0;
                cs_mem[i]   <= '1;
                lsel_mem[i] <= 1'b0;
            end
            first_q   <= '0;
            last_q    <= '0;
            mode_baud <= '0;
            mode_cpol <= 1'b0;
            mode_cpha <= 1'b0;
            mode_code <= '0;
        end else if (hw_en) begin
            case (host_sel_e'(hw_sel))
                SEL_TX:  tx_mem[hw_addr] <= hw_data;
                SEL_CMD: begin
                    cs_mem[hw_addr]   <= hw_data[CS_W-1:0];
                    lsel_mem[hw_addr] <= hw_data[LSEL_BIT];
                end
                SEL_PTR: begin
                    first_q <= hw_data[PTR_W-1:0];
                    last_q  <= hw_data[2*PTR_W-1:PTR_W];
                end
                SEL_MODE: begin
                    mode_baud <= hw_data[BAUD_W-1:0];
                    mode_cpol <= hw_data[CPOL_BIT];
                    mode_cpha <= hw_data[CPHA_BIT];
                    mode_code <= hw_data[CODE_LO +: CODE_W];
                end
                default: ;
            endcase
        end
    end

    // Transfer length for the current slot.
    always_comb begin
        if (!lsel_mem[ptr])          xfer_len = LEN_W'(8);
        else if (mode_code[CODE_W-1]) xfer_len = LEN_W'(mode_code);
        else                          xfer_len = LEN_W'(WORD_W);
    end

    // Receive memory write at the slot index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) rx_mem[i] <= '0;
        end else if (rx_we) begin
            rx_mem[ptr] <= rx_word;
        end
    end

    assign rd_data = rx_mem[rd_addr];

    qspi_sequencer #(.PTR_W(PTR_W), .CS_W(CS_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .first_ptr(first_q), .last_ptr(last_q), .cs_pat(cs_mem[ptr]),
        .fin(fin), .ptr(ptr), .busy(busy), .done(done), .csel(csel),
        .go(go), .rx_we(rx_we)
    );

    qspi_baud_gen #(.BAUD_W(BAUD_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(active), .baud(mode_baud), .tick(tick)
    );

    qspi_shift_engine #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .go(go), .tick(tick),
        .cpol(mode_cpol), .cpha(mode_cpha), .len(xfer_len),
        .tx_word(tx_mem[ptr]), .miso(miso), .sclk(sclk), .mosi(mosi),
        .active(active), .fin(fin), .rx_word(rx_word)
    );
endmodule

// File: rtl/qspi_queue_master_checker.sv
// Property checker for the queued SPI master, bound to the top.
// Assumes: cpol and baud are the mode register outputs.
module qspi_queue_master_checker #(
    parameter int CS_W   = 4,
    parameter int BAUD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic [CS_W-1:0]   csel,
    input logic              sclk,
    input logic              cpol,
    input logic [BAUD_W-1:0] baud
);
    logic       sclk_d;
    logic [7:0] gap;
    logic       armed;
    logic       tog;

    assign tog = (sclk != sclk_d);

    // Cycles since the previous serial clock toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            gap    <= '0;
            armed  <= 1'b0;
        end else begin
            sclk_d <= sclk;
            if (tog) begin
                gap   <= '0;
                armed <= 1'b1;
            end else if (gap != 8'hFF) begin
                gap <= gap + 1'b1;
            end
        end
    end

    assert_idle_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> csel == '1);

    assert_idle_sclk_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk == cpol);

    assert_done_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_busy_not_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    assert_stalled_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && $past(baud) == '0 && $stable(cpol)) |-> $stable(sclk));

    assert_min_half_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tog && armed && busy && $stable(cpol)) |-> gap >= 8'd1);
endmodule

bind qspi_queue_master qspi_queue_master_checker #(.CS_W(CS_W), .BAUD_W(BAUD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .csel(csel),
    .sclk(sclk), .cpol(mode_cpol), .baud(mode_baud)
);

// File: tb/qspi_queue_master_test.sv
`timescale 1ns/1ps
module qspi_queue_master_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_en = 1'b0;
    logic [1:0]  hw_sel = '0;
    logic [3:0]  hw_addr = '0;
    logic [15:0] hw_data = '0;
    logic        start = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        busy, done, sclk, mosi;
    logic        miso = 1'b0;
    logic [3:0]  csel;

    int checks = 0;
    int failures = 0;
    int mon_edges = 0;
    bit mon_busy = 1'b0;

    typedef struct {
        logic [3:0]  cs;
        int          len;
        logic [15:0] tx;
        logic [15:0] slv;
        bit          cpol;
        bit          cpha;
        int          div;
    } exp_t;
    exp_t exp_q[$];

    // Bench-side copies of what was written, used to form expectations.
    logic [15:0] tx_sh [16];
    logic [7:0]  cmd_sh[16];
    logic [15:0] slv_sh[16];
    int  cur_div;
    bit  cur_cpol, cur_cpha;
    int  cur_code;

    always #10 clk = ~clk;

    qspi_queue_master uut (
        .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .hw_sel(hw_sel),
        .hw_addr(hw_addr), .hw_data(hw_data), .start(start),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done),
        .sclk(sclk), .mosi(mosi), .miso(miso), .csel(csel)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] lmask(input int n);
        return (n >= 16) ? 16'hFFFF : 16'((32'd1 << n) - 1);
    endfunction

    function automatic int exp_len(input logic [7:0] cmd, input int code);
        if (!cmd[7]) return 8;
        return (code >= 8) ? code : 16;
    endfunction

    task automatic host_write(input int sel, input int addr, input logic [15:0] data);
        @(negedge clk);
        hw_en = 1'b1; hw_sel = 2'(sel); hw_addr = 4'(addr); hw_data = data;
        @(negedge clk);
        hw_en = 1'b0;
    endtask

    task automatic set_mode(input int baud, input bit cpol, input bit cpha, input int code);
        host_write(3, 0, {2'b00, 4'(code), cpha, cpol, 8'(baud)});
        cur_div = (baud < 2) ? 2 : baud;
        cur_cpol = cpol; cur_cpha = cpha; cur_code = code;
    endtask

    task automatic load_slot(input int idx, input logic [15:0] tx, input logic [7:0] cmd);
        host_write(0, idx, tx);
        host_write(1, idx, {8'h00, cmd});
        tx_sh[idx] = tx; cmd_sh[idx] = cmd;
    endtask

    // Driver: pushes one expected transfer per slot of the list.
    task automatic push_list(input int s, input int e);
        int i = s;
        forever begin
            exp_t it;
            it.cs = cmd_sh[i][3:0];
            it.len = exp_len(cmd_sh[i], cur_code);
            it.tx = tx_sh[i];
            it.slv = slv_sh[i];
            it.cpol = cur_cpol; it.cpha = cur_cpha; it.div = cur_div;
            exp_q.push_back(it);
            if (i == e) break;
            i = (i + 1) % 16;
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        while (exp_q.size() != 0 || mon_busy) @(negedge clk);
    endtask

    task automatic check_rx(input int s, input int e);
        int i = s;
        forever begin
            @(negedge clk); rd_addr = 4'(i); #1;
            check(rd_data == (slv_sh[i] & lmask(exp_len(cmd_sh[i], cur_code))),
                  $sformatf("R2 R5 rx slot %0d", i), rd_data,
                  slv_sh[i] & lmask(exp_len(cmd_sh[i], cur_code)));
            if (i == e) break;
            i = (i + 1) % 16;
        end
    endtask

    task automatic run_list(input int s, input int e, input bit poke);
        host_write(2, 0, 16'((e << 4) | s));
        push_list(s, e);
        pulse_start();
        check(busy == 1'b1, "R9 busy after start", busy, 1);
        check(done == 1'b0, "R9 done cleared by start", done, 0);
        if (poke) begin
            repeat (30) @(negedge clk);
            pulse_start();   // R10: ignored while busy
        end
        wait_idle();
        check(done == 1'b1, "R9 done after last slot", done, 1);
        check(csel == 4'hF, "R3 chip selects idle", csel, 4'hF);
        check(sclk == cur_cpol, "R6 sclk idle level", sclk, cur_cpol);
        check_rx(s, e);
    endtask

    // Monitor: models the slave and compares each transfer to the queue.
    initial begin
        forever begin
            exp_t it;
            logic [15:0] got;
            bit cs_ok, per_ok, pol_ok;
            int bi;
            time t_last;
            wait (exp_q.size() != 0);
            it = exp_q.pop_front();
            mon_busy = 1'b1;
            got = '0; cs_ok = 1; per_ok = 1; pol_ok = 1; bi = 0; t_last = 0;
            miso = it.slv[it.len - 1];
            for (int k = 0; k < 2 * it.len; k++) begin
                @(sclk); #1;
                mon_edges++;
                if (k == 0 && sclk == it.cpol) pol_ok = 0;
                if (k > 0 && ($time - t_last) != time'(it.div * 20)) per_ok = 0;
                t_last = $time;
                if ((k % 2) == int'(it.cpha)) begin
                    got = {got[14:0], mosi};
                    if (csel != it.cs) cs_ok = 0;
                end else if (!it.cpha) begin
                    bi++;
                    if (bi < it.len) miso = it.slv[it.len - 1 - bi];
                end else begin
                    miso = it.slv[it.len - 1 - bi];
                    bi++;
                end
            end
            check(got == (it.tx & lmask(it.len)), "R4 R11 mosi word", got, it.tx & lmask(it.len));
            check(cs_ok, "R3 chip select during transfer", cs_ok, 1);
            check(per_ok, "R7 half period", per_ok, 1);
            check(pol_ok, "R6 first edge direction", pol_ok, 1);
            mon_busy = 1'b0;
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            slv_sh[i] = 16'hA5C3 ^ 16'(i * 16'h1357);
            tx_sh[i] = '0; cmd_sh[i] = 8'h0F;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(busy == 0, "R1 busy", busy, 0);
        check(done == 0, "R1 done", done, 0);
        check(csel == 4'hF, "R1 csel", csel, 4'hF);
        check(sclk == 0, "R1 sclk", sclk, 0);

        // Mode 0, fastest divider, 8-bit slots with junk above bit 7 (R4).
        set_mode(2, 0, 0, 0);
        load_slot(0, 16'hFF3C, 8'h0E);
        load_slot(1, 16'h12A5, 8'h0D);
        load_slot(2, 16'hAB81, 8'h0B);
        load_slot(3, 16'h7F7E, 8'h07);
        run_list(0, 3, 0);

        // CPOL=1 CPHA=1, divider 5, programmable length 12 (R6, R7, R4).
        set_mode(5, 1, 1, 12);
        load_slot(5, 16'hFABC, 8'h83);
        load_slot(6, 16'h0123, 8'h85);
        load_slot(7, 16'h5A5A, 8'h09);
        run_list(5, 7, 0);

        // CPOL=0 CPHA=1, divider 1 acts as 2, length code 0 gives 16 (R7, R4).
        set_mode(1, 0, 1, 0);
        load_slot(9, 16'hC3E1, 8'h86);
        run_list(9, 9, 0);

        // CPOL=1 CPHA=0, divider 3, list wraps 14..1 reusing slots 0,1 (R2, R11).
        set_mode(3, 1, 0, 9);
        load_slot(14, 16'h01F5, 8'h8C);
        load_slot(15, 16'h9D2E, 8'h03);
        for (int i = 0; i < 16; i++) slv_sh[i] = slv_sh[i] ^ 16'h0F0F;
        run_list(14, 1, 0);

        // Start pulse during a run is ignored (R10).
        set_mode(4, 0, 0, 0);
        run_list(2, 3, 1);
        repeat (100) @(negedge clk);
        check(busy == 0, "R10 no restart after ignored start", busy, 0);
        check(exp_q.size() == 0, "R10 no extra transfer", exp_q.size(), 0);

        // Divider 0 stalls the run; nonzero divider resumes it (R8).
        set_mode(0, 1, 0, 0);
        cur_div = 4;
        host_write(2, 0, 16'h0044);
        push_list(4, 4);
        mon_edges = 0;
        pulse_start();
        repeat (200) @(negedge clk);
        check(busy == 1, "R8 busy held while stalled", busy, 1);
        check(mon_edges == 0, "R8 no clock edges while stalled", mon_edges, 0);
        check(sclk == 1, "R8 sclk parked at idle level", sclk, 1);
        host_write(3, 0, {2'b00, 4'd0, 1'b0, 1'b1, 8'd4});
        wait_idle();
        check(done == 1, "R8 R9 done after resume", done, 1);
        check_rx(4, 4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule